// File: doc/BRIEF.md
# I2C SCL Waveform Generator

This block turns a free-running peripheral clock into the SCL waveform of an I2C master. A single configuration word sets how long SCL stays low, how long it stays high, a shared power-of-two prescaler, and how long SDA must be held after each SCL falling edge. Each phase lasts `divider << exponent` plus a fixed offset of peripheral clocks. The offset is a parameter, `OFFSET`, with a default of 4. With equal dividers the SCL rate is the peripheral clock divided by twice that phase length.

The block drives an open-drain style enable, `scl_drive_low`, and reads the real bus level back on `scl_sense`. In the high phase the phase counter advances only while the bus is seen high, so a slave that holds SCL low stretches the clock. A one-cycle `phase_tick` marks the first cycle of every phase. A one-cycle `sda_strobe` tells the data shifter when it may change SDA after SCL has fallen. The word is sampled only on the clock edge that starts a phase, so software may rewrite it at any time.

Top module: `i2c_scl_wavegen`

## Requirements
- R1: While `enable` is low, `scl_drive_low`, `phase_tick` and `sda_strobe` are all 0 from the cycle after `enable` is sampled low. This also holds during reset. No pending hold strobe is issued after a disable.
- R2: A low phase lasts `(lo << e) + OFFSET` cycles. Here lo is word bits [7:0], e is the effective exponent, and OFFSET defaults to 4.
- R3: A high phase lasts `(hi << e) + OFFSET` cycles of sensed-high SCL. Here hi is word bits [15:8] and the raw exponent is bits [18:16].
- R4: A raw exponent above parameter `EXP_MAX` (default 6) is treated as `EXP_MAX`. With lo = 255 and raw exponent 7, a low phase lasts 16324 cycles.
- R5: During a high phase the counter holds in every cycle in which `scl_sense` is 0. A stretch of S cycles at the start of the high phase lengthens it by exactly S cycles.
- R6: Each phase takes its length from the word present at the clock edge that starts it. A word change in the middle of a phase does not alter that phase, and the following phase uses the new word.
- R7: `phase_tick` is 1 in the first cycle of every phase and 0 in every other cycle.
- R8: `sda_strobe` is a single-cycle pulse that appears HOLD + 3 cycles after the first cycle of a low phase. HOLD is word bits [29:24] and ranges from 0 to 63.
- R9: After `enable` is sampled high from the disabled state, the next cycle is the first cycle of a low phase.
- R10: Dividers of 0 give phases of exactly OFFSET cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the generator; low releases SCL and idles |
| cfg_word | input | 32 | Timing word: lo [7:0], hi [15:8], exponent [18:16], hold [29:24] |
| scl_sense | input | 1 | Sensed SCL bus level |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| phase_tick | output | 1 | One-cycle pulse in the first cycle of each phase |
| sda_strobe | output | 1 | One-cycle pulse when SDA may change after a fall |

## Verification
The phase lengths are measured with unequal low and high dividers, so a swap of the two fields shows up. They are also measured with a nonzero exponent, which tells the shift apart from a multiply or an add, and with zero dividers, which leaves only the offset. A raw exponent of 7 separates the clamp from a plain shift. A stretch held over the first cycles of a high phase must lengthen that phase by exactly its own duration, which catches a counter that keeps running. The hold delay is measured at a middle value and at its maximum. A word rewritten in the middle of a low phase, and a disable in the middle of a pending hold, show whether sampling happens only at the boundary and whether the pending strobe is cancelled.

// File: rtl/i2c_wg_pkg.sv
package i2c_wg_pkg;

  // Field widths of the configuration word
  localparam int DIV_W   = 8;
  localparam int EXP_W   = 3;
  localparam int HOLD_W  = 6;
  localparam int CFG_W   = 32;

  // Field positions inside the word
  localparam int LO_LSB   = 0;
  localparam int HI_LSB   = 8;
  localparam int EXP_LSB  = 16;
  localparam int HOLD_LSB = 24;

  // Derived widths
  localparam int EXP_TOP = (1 << EXP_W) - 1;
  localparam int PHASE_W = DIV_W + EXP_TOP + 1;
  localparam int HCNT_W  = HOLD_W + 1;

  typedef struct packed {
    logic [HOLD_W-1:0] hold;
    logic [EXP_W-1:0]  expo;
    logic [DIV_W-1:0]  hi;
    logic [DIV_W-1:0]  lo;
  } wg_cfg_t;

  typedef enum logic [1:0] {
    WG_IDLE = 2'd0,
    WG_LOW  = 2'd1,
    WG_HIGH = 2'd2
  } wg_state_e;

  // Length of one phase in peripheral clocks
  function automatic logic [PHASE_W-1:0] phase_cycles(
    input logic [DIV_W-1:0] div,
    input logic [EXP_W-1:0] expo,
    input int unsigned      offset
  );
    logic [PHASE_W-1:0] scaled;
    scaled = PHASE_W'(div) << expo;
    return scaled + PHASE_W'(offset);
  endfunction

  // Delay from SCL fall to SDA strobe in peripheral clocks
  function automatic logic [HCNT_W-1:0] hold_cycles(
    input logic [HOLD_W-1:0] hold
  );
    return HCNT_W'(hold) + HCNT_W'(3);
  endfunction

endpackage

// File: rtl/wg_cfg_decode.sv
module wg_cfg_decode
  import i2c_wg_pkg::*;
#(
  parameter int unsigned EXP_MAX = 6
) (
  input  logic [CFG_W-1:0] word,
  output wg_cfg_t          cfg
);

  localparam logic [EXP_W-1:0] EXP_CAP = EXP_W'(EXP_MAX);

  logic [EXP_W-1:0] raw_exp;

  assign raw_exp = word[EXP_LSB +: EXP_W];

  always_comb begin
    cfg.lo   = word[LO_LSB +: DIV_W];
    cfg.hi   = word[HI_LSB +: DIV_W];
    cfg.hold = word[HOLD_LSB +: HOLD_W];
    cfg.expo = (raw_exp > EXP_CAP) ? EXP_CAP : raw_exp;
  end

endmodule

// File: rtl/wg_phase_ctrl.sv
module wg_phase_ctrl
  import i2c_wg_pkg::*;
#(
  parameter int unsigned OFFSET = 4
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    enable,
  input  logic    scl_sense,
  input  wg_cfg_t cfg,
  output logic    scl_low,
  output logic    phase_tick,
  output logic    fall_evt
);

  wg_state_e          state_q, state_d;
  logic [PHASE_W-1:0] cnt_q, cnt_d;
  logic               tick_q;
  logic               boundary;
  logic               cnt_zero;
  logic [PHASE_W-1:0] lo_len, hi_len;

  assign lo_len   = phase_cycles(cfg.lo, cfg.expo, OFFSET);
  assign hi_len   = phase_cycles(cfg.hi, cfg.expo, OFFSET);
  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    boundary = 1'b0;
    if (!enable) begin
      state_d = WG_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        WG_IDLE: begin
          state_d  = WG_LOW;
          cnt_d    = lo_len - PHASE_W'(1);
          boundary = 1'b1;
        end
        WG_LOW: begin
          if (cnt_zero) begin
            state_d  = WG_HIGH;
            cnt_d    = hi_len - PHASE_W'(1);
            boundary = 1'b1;
          end else begin
            cnt_d = cnt_q - PHASE_W'(1);
          end
        end
        WG_HIGH: begin
          if (scl_sense) begin
            if (cnt_zero) begin
              state_d  = WG_LOW;
              cnt_d    = lo_len - PHASE_W'(1);
              boundary = 1'b1;
            end else begin
              cnt_d = cnt_q - PHASE_W'(1);
            end
          end
        end
        default: begin
          state_d = WG_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WG_IDLE;
      cnt_q   <= '0;
      tick_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      tick_q  <= boundary;
    end
  end

  assign scl_low    = (state_q == WG_LOW);
  assign phase_tick = tick_q;
  assign fall_evt   = boundary && (state_d == WG_LOW);

  // R7: a tick only appears in a cycle where the SCL drive just changed
  assert_tick_marks_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    phase_tick |-> (scl_low != $past(scl_low)));

  // R5: a low sensed SCL freezes the high-phase count
  assert_stretch_freezes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WG_HIGH && enable && !scl_sense) |=> (state_q == WG_HIGH && $stable(cnt_q)));

  // R2: leaving the low phase only happens with an exhausted counter
  assert_low_exit_on_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WG_LOW && enable && !cnt_zero) |=> (state_q == WG_LOW));

endmodule

// File: rtl/wg_hold_delay.sv
module wg_hold_delay
  import i2c_wg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              fall_evt,
  input  logic [HOLD_W-1:0] hold_val,
  output logic              sda_strobe
);

  logic [HCNT_W-1:0] hcnt_q;
  logic              busy_q;
  logic              strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q   <= '0;
      busy_q   <= 1'b0;
      strobe_q <= 1'b0;
    end else if (!enable) begin
      hcnt_q   <= '0;
      busy_q   <= 1'b0;
      strobe_q <= 1'b0;
    end else if (fall_evt) begin
      // first low cycle counts as one; strobe register adds another
      hcnt_q   <= hold_cycles(hold_val) - HCNT_W'(1);
      busy_q   <= 1'b1;
      strobe_q <= 1'b0;
    end else if (busy_q) begin
      if (hcnt_q == '0) begin
        strobe_q <= 1'b1;
        busy_q   <= 1'b0;
      end else begin
        hcnt_q   <= hcnt_q - HCNT_W'(1);
        strobe_q <= 1'b0;
      end
    end else begin
      strobe_q <= 1'b0;
    end
  end

  assign sda_strobe = strobe_q;

  // R8: the strobe is a single-cycle pulse
  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sda_strobe |=> !sda_strobe);

  // R8: a strobe is only issued by a timer that was running
  assert_strobe_from_timer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_strobe) |-> $past(busy_q));

endmodule

// File: rtl/i2c_scl_wavegen.sv
module i2c_scl_wavegen
  import i2c_wg_pkg::*;
#(
  parameter int unsigned OFFSET  = 4,
  parameter int unsigned EXP_MAX = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic [31:0] cfg_word,
  input  logic        scl_sense,
  output logic        scl_drive_low,
  output logic        phase_tick,
  output logic        sda_strobe
);

  wg_cfg_t cfg;
  logic    fall_evt;

  wg_cfg_decode #(
    .EXP_MAX (EXP_MAX)
  ) u_decode (
    .word (cfg_word),
    .cfg  (cfg)
  );

  wg_phase_ctrl #(
    .OFFSET (OFFSET)
  ) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .scl_sense  (scl_sense),
    .cfg        (cfg),
    .scl_low    (scl_drive_low),
    .phase_tick (phase_tick),
    .fall_evt   (fall_evt)
  );

  wg_hold_delay u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .fall_evt   (fall_evt),
    .hold_val   (cfg.hold),
    .sda_strobe (sda_strobe)
  );

  // R1: disabling releases SCL and silences both pulse outputs
  assert_quiet_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!scl_drive_low && !phase_tick && !sda_strobe));

  // R9: enabling from idle starts with a low phase
  assert_start_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !$past(enable) && !scl_drive_low) |=> scl_drive_low);

endmodule

// File: tb/i2c_scl_wavegen_tb_top.sv
module i2c_scl_wavegen_tb_top;

  localparam int OFS  = 4;
  localparam int EMAX = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [31:0] cfg_word = '0;
  logic        stretch = 1'b0;
  logic        scl_sense;
  logic        scl_drive_low;
  logic        phase_tick;
  logic        sda_strobe;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  // open-drain bus model: low when driven or held by a slave
  assign scl_sense = !scl_drive_low && !stretch;

  i2c_scl_wavegen #(.OFFSET(OFS), .EXP_MAX(EMAX)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .cfg_word      (cfg_word),
    .scl_sense     (scl_sense),
    .scl_drive_low (scl_drive_low),
    .phase_tick    (phase_tick),
    .sda_strobe    (sda_strobe)
  );

  function automatic logic [31:0] mk(int lo, int hi, int e, int h);
    logic [31:0] w;
    w = '0;
    w[7:0]   = lo[7:0];
    w[15:8]  = hi[7:0];
    w[18:16] = e[2:0];
    w[29:24] = h[5:0];
    return w;
  endfunction

  function automatic int plen(int div, int e);
    int ee;
    ee = (e > EMAX) ? EMAX : e;
    return div * (1 << ee) + OFS;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // wait for a fresh start of a phase at the given drive level
  task automatic sync_to(input logic lvl);
    int guard = 0;
    do begin @(negedge clk); guard++; end while (scl_drive_low == lvl && guard < 40000);
    do begin @(negedge clk); guard++; end while (scl_drive_low != lvl && guard < 80000);
  endtask

  // called at the first cycle of a phase; returns at the first cycle of the next
  task automatic measure(input logic lvl, input int stretch_n, input int expv, input string tag);
    int len  = 1;
    int bad  = 0;
    int rem  = stretch_n;
    check(phase_tick == 1'b1, "R7 tick at phase start", int'(phase_tick), 1);
    if (rem > 0) stretch = 1'b1;
    forever begin
      @(negedge clk);
      if (rem > 0) begin
        rem--;
        if (rem == 0) stretch = 1'b0;
      end
      if (scl_drive_low != lvl || len > 40000) break;
      len++;
      if (phase_tick) bad++;
    end
    check(len == expv, tag, len, expv);
    check(bad == 0, "R7 no tick inside phase", bad, 0);
  endtask

  task automatic t_reset;
    check(!scl_drive_low && !phase_tick && !sda_strobe, "R1 reset outputs quiet",
          int'({scl_drive_low, phase_tick, sda_strobe}), 0);
  endtask

  task automatic t_basic;
    cfg_word = mk(3, 5, 0, 0);
    enable   = 1'b1;
    @(negedge clk);
    check(scl_drive_low == 1'b1, "R9 low phase right after enable", int'(scl_drive_low), 1);
    measure(1'b1, 0, plen(3, 0), "R2 low length lo=3 e=0");
    measure(1'b0, 0, plen(5, 0), "R3 high length hi=5 e=0");
    measure(1'b1, 0, plen(3, 0), "R2 second low length");
  endtask

  task automatic t_prescale;
    cfg_word = mk(10, 1, 2, 0);
    sync_to(1'b1);
    measure(1'b1, 0, plen(10, 2), "R2 low length lo=10 e=2");
    measure(1'b0, 0, plen(1, 2), "R3 high length hi=1 e=2");
  endtask

  task automatic t_zero;
    cfg_word = mk(0, 0, 0, 0);
    sync_to(1'b1);
    measure(1'b1, 0, OFS, "R10 low length zero divider");
    measure(1'b0, 0, OFS, "R10 high length zero divider");
  endtask

  task automatic t_clamp;
    cfg_word = mk(255, 0, 7, 0);
    sync_to(1'b1);
    measure(1'b1, 0, 255 * 64 + OFS, "R4 exponent clamp lo=255 e=7");
  endtask

  task automatic t_stretch;
    cfg_word = mk(2, 3, 0, 0);
    sync_to(1'b1);
    measure(1'b1, 0, plen(2, 0), "R2 low before stretch");
    measure(1'b0, 12, plen(3, 0) + 12, "R5 stretched high length");
    measure(1'b1, 0, plen(2, 0), "R2 low after stretch");
    measure(1'b0, 0, plen(3, 0), "R5 unstretched high length");
  endtask

  task automatic t_midchange;
    cfg_word = mk(3, 5, 0, 0);
    sync_to(1'b1);
    cfg_word = mk(20, 7, 0, 0);
    measure(1'b1, 0, plen(3, 0), "R6 current low keeps old word");
    measure(1'b0, 0, plen(7, 0), "R6 next high uses new word");
    measure(1'b1, 0, plen(20, 0), "R6 next low uses new word");
  endtask

  task automatic t_hold(input int h, input int e);
    int n = 0;
    cfg_word = mk(40, 2, e, h);
    sync_to(1'b1);
    while (!sda_strobe && n < 200) begin
      @(negedge clk);
      n++;
    end
    check(n == h + 3, "R8 strobe delay after fall", n, h + 3);
    @(negedge clk);
    check(sda_strobe == 1'b0, "R8 strobe lasts one cycle", int'(sda_strobe), 0);
  endtask

  task automatic t_disable;
    int seen = 0;
    cfg_word = mk(40, 2, 0, 10);
    sync_to(1'b1);
    @(negedge clk);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(scl_drive_low == 1'b0, "R1 SCL released after disable", int'(scl_drive_low), 1'b0);
    for (int i = 0; i < 30; i++) begin
      if (scl_drive_low || phase_tick || sda_strobe) seen++;
      @(negedge clk);
    end
    check(seen == 0, "R1 no drive, tick or pending strobe while off", seen, 0);
    cfg_word = mk(3, 5, 0, 0);
    enable   = 1'b1;
    @(negedge clk);
    check(scl_drive_low == 1'b1, "R9 re-enable starts low", int'(scl_drive_low), 1);
    measure(1'b1, 0, plen(3, 0), "R2 low length after re-enable");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_prescale();
    t_zero();
    t_stretch();
    t_midchange();
    t_hold(10, 0);
    t_hold(63, 1);
    t_hold(0, 0);
    t_disable();
    t_clamp();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule